// File: doc/BRIEF.md
# Data-Processing ALU

This block is the combinational result stage of a 32-bit data-processing pipe. It receives a first source operand, a second source operand that has already been through the separate shifter, a 4-bit operation code, the carry bit produced by that shifter and the current overflow flag. In the same cycle it returns a 32-bit result together with negative, zero, carry and overflow flags. Every operation reads exactly two sources and produces one result; there is no third input.

Because only the second source can be shifted upstream, the operation set includes the forms that this asymmetry needs: clearing bits of the first source under a mask in the second, copying or inverting the (shifted) second source, and subtracting in either direction. Multiply-by-constant sequences are built by feeding the shifted first source into the second port and using add or reverse-subtract. Codes that name no operation give a zero result and raise an illegal-code output so that the decode stage can trap.

Top module: `dp_alu`

## Requirements
- R1: Code 0 gives first AND second, code 12 gives first OR second, code 1 gives first XOR second, all bit by bit.
- R2: Code 14 (bit clear) gives first AND NOT second: each bit set in the second operand forces that result bit to 0, e.g. 0x12345678 with 0x0000FFFF gives 0x12340000.
- R3: Code 13 (move) gives the second operand unchanged; code 15 (move inverted) gives its ones' complement, so an all-zero second operand gives all ones.
- R4: Code 4 (add) gives the sum modulo 2^W; C is the carry out of bit W-1 and V is set when two operands of equal sign give a result of the other sign.
- R5: Code 2 (subtract) gives first minus second modulo 2^W; C is 1 when no borrow occurs (first >= second, unsigned) and V is the signed overflow of the difference.
- R6: Code 3 (reverse subtract) gives second minus first with C = 1 when second >= first (unsigned) and V its signed overflow; with the second operand equal to the first shifted left by 3 the result is 7 times the first.
- R7: Codes 5 to 11 give result 0 and raise the illegal-code output; the nine defined codes keep it low.
- R8: For every code N equals result bit W-1 and Z is 1 exactly when the result is all zeros.
- R9: For the logical codes (0, 1, 12, 13, 14, 15) and the illegal codes, C equals the shifter carry input and V equals the incoming overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First source operand |
| opb | input | WIDTH | Second source operand, already shifted |
| op | input | 4 | Operation code |
| shift_carry | input | 1 | Carry out of the upstream shifter |
| v_in | input | 1 | Current overflow flag, kept by logical codes |
| result | output | WIDTH | Operation result |
| flag_n | output | 1 | Negative flag (result sign bit) |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / not-borrow flag |
| flag_v | output | 1 | Signed overflow flag |
| bad_op | output | 1 | Operation code names no operation |

## Verification
An 8-bit copy of the unit is swept over every first operand against a stepped second operand for all sixteen codes, which separates the carry and overflow rules of add, subtract and reverse subtract at every sign and magnitude boundary and shows that each undefined code yields zero. The full-width unit is driven with the corner values 0, all ones and the sign bit alone in every pairing, which tells the borrow sense of the two subtractions apart and exercises the zero and negative flags at their extremes. Random full-width operands, the bit-clear and low-twelve-bit masking examples and the times-seven reverse-subtract identity check the bitwise paths and the operand swap in the shared adder.

// File: rtl/dp_alu_pkg.sv
// Package: shared operation codes and decode types for the data-processing ALU.
// Assumes a 4-bit operation field; unlisted codes are illegal.
package dp_alu_pkg;

    // Operation codes (4-bit field)
    typedef enum logic [3:0] {
        OPC_AND = 4'd0,
        OPC_XOR = 4'd1,
        OPC_SUB = 4'd2,
        OPC_RSB = 4'd3,
        OPC_ADD = 4'd4,
        OPC_ORR = 4'd12,
        OPC_MOV = 4'd13,
        OPC_BIC = 4'd14,
        OPC_MVN = 4'd15
    } alu_opc_e;

    // Which datapath supplies the result
    typedef enum logic [1:0] {
        PATH_NONE  = 2'd0,
        PATH_LOGIC = 2'd1,
        PATH_ARITH = 2'd2
    } alu_path_e;

    // Bitwise function selected inside the logic unit
    typedef enum logic [2:0] {
        LF_AND = 3'd0,
        LF_ORR = 3'd1,
        LF_XOR = 3'd2,
        LF_BIC = 3'd3,
        LF_MOV = 3'd4,
        LF_MVN = 3'd5
    } logic_fn_e;

    // Decoded control word
    typedef struct packed {
        alu_path_e path;
        logic_fn_e lfn;
        logic      swap;   // adder takes opb as minuend
        logic      negate; // adder inverts its second input and adds one
    } alu_ctrl_t;

endpackage

// File: rtl/dp_alu_decode.sv
// Module: dp_alu_decode
// Turns the 4-bit operation code into a control word for the datapaths.
// Assumes nothing about the operands; purely combinational.
module dp_alu_decode
    import dp_alu_pkg::*;
(
    input  logic [3:0] op,
    output alu_ctrl_t  ctrl,
    output logic       illegal
);

    // Map each code to path, logic function and adder controls
    always_comb begin
        ctrl.path   = PATH_NONE;
        ctrl.lfn    = LF_AND;
        ctrl.swap   = 1'b0;
        ctrl.negate = 1'b0;
        illegal     = 1'b0;
        case (op)
            OPC_AND: begin ctrl.path = PATH_LOGIC; ctrl.lfn = LF_AND; end
            OPC_XOR: begin ctrl.path = PATH_LOGIC; ctrl.lfn = LF_XOR; end
            OPC_ORR: begin ctrl.path = PATH_LOGIC; ctrl.lfn = LF_ORR; end
            OPC_MOV: begin ctrl.path = PATH_LOGIC; ctrl.lfn = LF_MOV; end
            OPC_BIC: begin ctrl.path = PATH_LOGIC; ctrl.lfn = LF_BIC; end
            OPC_MVN: begin ctrl.path = PATH_LOGIC; ctrl.lfn = LF_MVN; end
            OPC_ADD: begin ctrl.path = PATH_ARITH; end
            OPC_SUB: begin ctrl.path = PATH_ARITH; ctrl.negate = 1'b1; end
            OPC_RSB: begin
                ctrl.path   = PATH_ARITH;
                ctrl.negate = 1'b1;
                ctrl.swap   = 1'b1;
            end
            default: illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/dp_alu_logic.sv
// Module: dp_alu_logic
// Bitwise unit: AND, OR, XOR, bit clear, move and move inverted.
// Assumes both operands are WIDTH bits; each bit slice is independent.
module dp_alu_logic
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_fn_e        fn,
    output logic [WIDTH-1:0] y
);

    // One identical slice per bit position
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Pick the bit function for this slice
        always_comb begin
            case (fn)
                LF_AND:  y[i] = a[i] & b[i];
                LF_ORR:  y[i] = a[i] | b[i];
                LF_XOR:  y[i] = a[i] ^ b[i];
                LF_BIC:  y[i] = a[i] & ~b[i];
                LF_MOV:  y[i] = b[i];
                LF_MVN:  y[i] = ~b[i];
                default: y[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/dp_alu_arith.sv
// Module: dp_alu_arith
// Single shared adder for add, subtract and reverse subtract.
// Assumes subtraction is done as x + ~y + 1; carry out is then not-borrow.
module dp_alu_arith #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             swap,
    input  logic             negate,
    output logic [WIDTH-1:0] sum,
    output logic             carry,
    output logic             ovf
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] x_in;
    logic [WIDTH-1:0] y_sel;
    logic [WIDTH-1:0] y_in;
    logic [WIDTH:0]   wide;

    // Order the operands and condition the second adder input
    always_comb begin
        x_in  = swap ? b : a;
        y_sel = swap ? a : b;
        y_in  = negate ? ~y_sel : y_sel;
    end

    // Add with carry-in equal to the negate control
    always_comb begin
        wide = {1'b0, x_in} + {1'b0, y_in} + {{WIDTH{1'b0}}, negate};
        sum  = wide[MSB:0];
    end

    // Carry out and signed overflow of the conditioned addition
    always_comb begin
        carry = wide[WIDTH];
        ovf   = (x_in[MSB] == y_in[MSB]) && (wide[MSB] != x_in[MSB]);
    end

endmodule

// File: rtl/dp_alu_flags.sv
// Module: dp_alu_flags
// Builds N, Z, C and V from the selected result and the source of the carry.
// Assumes arithmetic codes own C and V; all other codes pass them through.
module dp_alu_flags #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] res,
    input  logic             from_adder,
    input  logic             add_c,
    input  logic             add_v,
    input  logic             shift_carry,
    input  logic             v_in,
    output logic             n,
    output logic             z,
    output logic             c,
    output logic             v
);

    // Sign and zero detection on the final result
    always_comb begin
        n = res[WIDTH-1];
        z = ~|res;
    end

    // Carry and overflow source selection
    always_comb begin
        c = from_adder ? add_c : shift_carry;
        v = from_adder ? add_v : v_in;
    end

endmodule

// File: rtl/dp_alu.sv
// Module: dp_alu (top)
// Combinational data-processing ALU: two sources, one result, four flags.
// Assumes opb has already passed through the shifter and shift_carry is its
// carry; an undefined code yields zero and raises bad_op.
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [3:0]       op,
    input  logic             shift_carry,
    input  logic             v_in,
    output logic [WIDTH-1:0] result,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_v,
    output logic             bad_op
);

    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] arith_y;
    logic             arith_c;
    logic             arith_v;
    logic             use_adder;

    dp_alu_decode u_decode (
        .op      (op),
        .ctrl    (ctrl),
        .illegal (bad_op)
    );

    dp_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a  (opa),
        .b  (opb),
        .fn (ctrl.lfn),
        .y  (logic_y)
    );

    dp_alu_arith #(.WIDTH(WIDTH)) u_arith (
        .a      (opa),
        .b      (opb),
        .swap   (ctrl.swap),
        .negate (ctrl.negate),
        .sum    (arith_y),
        .carry  (arith_c),
        .ovf    (arith_v)
    );

    // Result multiplexer over the two datapaths; illegal gives zero
    always_comb begin
        use_adder = (ctrl.path == PATH_ARITH);
        case (ctrl.path)
            PATH_LOGIC: result = logic_y;
            PATH_ARITH: result = arith_y;
            default:    result = '0;
        endcase
    end

    dp_alu_flags #(.WIDTH(WIDTH)) u_flags (
        .res         (result),
        .from_adder  (use_adder),
        .add_c       (arith_c),
        .add_v       (arith_v),
        .shift_carry (shift_carry),
        .v_in        (v_in),
        .n           (flag_n),
        .z           (flag_z),
        .c           (flag_c),
        .v           (flag_v)
    );

endmodule

// File: rtl/dp_alu_chk.sv
// Module: dp_alu_chk
// Assertion checker bound to dp_alu; watches ports only.
module dp_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [3:0]       op,
    input logic             shift_carry,
    input logic             v_in,
    input logic [WIDTH-1:0] result,
    input logic             flag_n,
    input logic             flag_z,
    input logic             flag_c,
    input logic             flag_v,
    input logic             bad_op
);

    logic passthru;
    logic undefined;

    // Classify the code from the opcode table
    always_comb begin
        undefined = (op >= 4'd5) && (op <= 4'd11);
        passthru  = undefined || op == 4'd0 || op == 4'd1 || op >= 4'd12;
    end

    // Port-level properties of the combinational result
    always_comb begin
        a_r7_illegal_zero: assert (!bad_op || result == '0);
        a_r7_illegal_flag: assert (bad_op == undefined);
        a_r8_zero_flag:    assert (flag_z == (result == '0));
        a_r8_neg_flag:     assert (flag_n == result[WIDTH-1]);
        a_r9_carry_pass:   assert (!passthru || flag_c == shift_carry);
        a_r9_ovf_keep:     assert (!passthru || flag_v == v_in);
        a_r2_bic_clears:   assert (op != 4'd14 || (result & opb) == '0);
        a_r3_mvn_inverts:  assert (op != 4'd15 || (result ^ opb) == '1);
        a_r1_and_subset:   assert (op != 4'd0 || (result & ~opa) == '0);
    end

endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .opa         (opa),
    .opb         (opb),
    .op          (op),
    .shift_carry (shift_carry),
    .v_in        (v_in),
    .result      (result),
    .flag_n      (flag_n),
    .flag_z      (flag_z),
    .flag_c      (flag_c),
    .flag_v      (flag_v),
    .bad_op      (bad_op)
);

// File: tb/test_dp_alu.sv
// Bench: sweeps an 8-bit copy near-exhaustively and drives the 32-bit unit
// with corners, document-style examples and random operands.
module test_dp_alu;

    logic clk = 1'b0;
    int   total = 0;
    int   bad = 0;
    int   cycles = 0;
    bit   done = 1'b0;

    // 250 MHz clock
    always #2 clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // 32-bit instance
    logic [31:0] a32, b32, r32;
    logic [3:0]  op32;
    logic        sc32, vi32, n32, z32, c32, v32, x32;

    dp_alu #(.WIDTH(32)) i_dp_alu (
        .opa(a32), .opb(b32), .op(op32), .shift_carry(sc32), .v_in(vi32),
        .result(r32), .flag_n(n32), .flag_z(z32), .flag_c(c32),
        .flag_v(v32), .bad_op(x32)
    );

    // 8-bit instance for the sweep
    logic [7:0] a8, b8, r8;
    logic [3:0] op8;
    logic       sc8, vi8, n8, z8, c8, v8, x8;

    dp_alu #(.WIDTH(8)) i_dp_alu_w8 (
        .opa(a8), .opb(b8), .op(op8), .shift_carry(sc8), .v_in(vi8),
        .result(r8), .flag_n(n8), .flag_z(z8), .flag_c(c8),
        .flag_v(v8), .bad_op(x8)
    );

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1, 4'd12: return "R1";
            4'd14:             return "R2";
            4'd13, 4'd15:      return "R3";
            4'd4:              return "R4";
            4'd2:              return "R5";
            4'd3:              return "R6";
            default:           return "R7";
        endcase
    endfunction

    // Reference model computed from the requirements and compared
    task automatic check(input int w, input longint unsigned a, input longint unsigned b,
                         input logic [3:0] op, input logic sc, input logic vi,
                         input longint unsigned ra, input logic na, input logic za,
                         input logic ca, input logic va, input logic xa);
        longint unsigned m = (64'd1 << w) - 1;
        longint unsigned r = 0;
        logic c = sc, v = vi, x = 1'b0, n, z;
        logic sa = a[w-1], sb = b[w-1];
        string rq = req_of(op);
        string fr;
        case (op)
            4'd0:  r = a & b;
            4'd12: r = a | b;
            4'd1:  r = a ^ b;
            4'd14: r = a & ~b & m;
            4'd13: r = b;
            4'd15: r = ~b & m;
            4'd4: begin
                r = (a + b) & m;
                c = (a + b) > m;
                v = (sa == sb) && (r[w-1] != sa);
            end
            4'd2: begin
                r = (a - b) & m;
                c = a >= b;
                v = (sa != sb) && (r[w-1] != sa);
            end
            4'd3: begin
                r = (b - a) & m;
                c = b >= a;
                v = (sa != sb) && (r[w-1] != sb);
            end
            default: begin r = 0; x = 1'b1; end
        endcase
        n = r[w-1];
        z = (r == 0);
        fr = (op == 4'd2 || op == 4'd3 || op == 4'd4) ? rq : "R9";
        total++;
        if (ra != r) begin
            bad++;
            $display("FAIL %s w=%0d op=%0d a=%h b=%h result actual=%h expected=%h", rq, w, op, a, b, ra, r);
        end else if (xa != x) begin
            bad++;
            $display("FAIL R7 w=%0d op=%0d illegal actual=%b expected=%b", w, op, xa, x);
        end else if (na != n || za != z) begin
            bad++;
            $display("FAIL R8 w=%0d op=%0d nz actual=%b%b expected=%b%b", w, op, na, za, n, z);
        end else if (ca != c || va != v) begin
            bad++;
            $display("FAIL %s w=%0d op=%0d a=%h b=%h cv actual=%b%b expected=%b%b", fr, w, op, a, b, ca, va, c, v);
        end
    endtask

    task automatic run32(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op,
                         input logic sc, input logic vi);
        a32 = a; b32 = b; op32 = op; sc32 = sc; vi32 = vi;
        #1;
        check(32, a, b, op, sc, vi, r32, n32, z32, c32, v32, x32);
    endtask

    task automatic lit(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s literal actual=%h expected=%h", rq, act, exp);
        end
    endtask

    localparam logic [31:0] CORNERS [3] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000};

    initial begin
        a32 = '0; b32 = '0; op32 = '0; sc32 = 0; vi32 = 0;
        a8 = '0; b8 = '0; op8 = '0; sc8 = 0; vi8 = 0;
        #1;
        // Idle state: AND of zeros gives zero, Z set (R8)
        lit("R8", {31'd0, z32}, 32'd1);

        // R2: bit clear example
        run32(32'h1234_5678, 32'h0000_FFFF, 4'd14, 1'b0, 1'b0);
        lit("R2", r32, 32'h1234_0000);
        // R1: low 12-bit mask
        run32(32'hB6A4_3D9A, 32'h0000_0FFF, 4'd0, 1'b1, 1'b1);
        lit("R1", r32, 32'h0000_0D9A);
        // R3: move inverted of zero
        run32(32'h5555_5555, 32'h0, 4'd15, 1'b0, 1'b0);
        lit("R3", r32, 32'hFFFF_FFFF);
        // R6: reverse subtract with shifted first gives times seven
        for (int k = 0; k < 8; k++) begin
            logic [31:0] q = $urandom;
            run32(q, q << 3, 4'd3, 1'b0, 1'b0);
            lit("R6", r32, q * 32'd7);
        end

        // Corner pairings for every code
        for (int o = 0; o < 16; o++)
            for (int i = 0; i < 3; i++)
                for (int j = 0; j < 3; j++) begin
                    run32(CORNERS[i], CORNERS[j], 4'(o), 1'(i), 1'(j));
                    run32(CORNERS[i], CORNERS[j], 4'(o), ~1'(i), ~1'(j));
                end

        // Random full-width operands
        for (int k = 0; k < 300; k++)
            run32($urandom, $urandom, 4'($urandom), 1'($urandom), 1'($urandom));

        // Near-exhaustive 8-bit sweep (R4 R5 R6 R7 carry and overflow)
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b += 3)
                for (int o = 0; o < 16; o++) begin
                    a8 = 8'(a); b8 = 8'(b); op8 = 4'(o);
                    sc8 = a[0]; vi8 = b[1];
                    #1;
                    check(8, longint'(a), longint'(b), op8, sc8, vi8,
                          longint'(r8), n8, z8, c8, v8, x8);
                end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule